// File: doc/BRIEF.md
# Synchronous serial port raw interrupt status

This block produces the unmasked interrupt flags of a synchronous serial port. Two of the flags are levels that follow the transmit and receive FIFO fill counts. The other two are sticky event flags, for a receive time-out and a receive overrun. The FIFOs, the serializer and the time-out counter are outside the block, and their fill counts and event pulses arrive as inputs.

An end-of-transmission mode bit changes what the transmit flag means:

- With the mode bit clear, the transmit flag is a watermark that marks a FIFO at half capacity or below.
- With the mode bit set, the transmit flag rises only when the FIFO is empty and the serializer has finished shifting out its last bit.

Software reads the four flags as a 32-bit status word over a simple word-addressed register bus. It clears the sticky flags by writing ones to a separate clear register. The status word cannot be written. Masking and the masked status view are done downstream, using the `raw_flags` vector.

Top module: `ssp_raw_irq_status`

## Requirements
- R1: The status word at word address `STATUS_IDX` (default 0) is read-only: a bus write to it changes no flag. Its bits 31:4 always read 0, and a read of any other address, including the clear register, returns 0.
- R2: After reset the status word reads 0x8. Bit 3 (transmit) is 1, and bits 2 (receive), 1 (time-out) and 0 (overrun) are 0.
- R3: With `eot_mode` = 0, bit 3 is 1 when `tx_level` <= DEPTH/2 and 0 when `tx_level` > DEPTH/2. `shifter_busy` has no effect in this mode.
- R4: With `eot_mode` = 1, bit 3 is 1 only when `tx_level` = 0 and `shifter_busy` = 0. It is 0 whenever the FIFO holds any entry or the serializer is busy.
- R5: Bit 2 is 1 when `rx_level` >= DEPTH/2 and 0 when `rx_level` < DEPTH/2.
- R6: A one-cycle pulse on `rx_timeout_evt` sets bit 1. Bit 1 stays set until a write to the clear register at word address `CLEAR_IDX` (default 1) with write-data bit 1 equal to 1.
- R7: A one-cycle pulse on `rx_overrun_evt` sets bit 0. Bit 0 stays set until a write to the clear register with write-data bit 0 equal to 1.
- R8: A 0 in a clear-register write bit leaves the matching flag unchanged. When a set pulse and a clearing write for the same flag arrive in the same cycle, the flag ends up set.
- R9: Bits 3 and 2 are registered. They take their new value at the first rising clock edge after `tx_level`, `rx_level`, `shifter_busy` or `eot_mode` changes, and keep the old value before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_level | input | CNT_W (4) | Transmit FIFO entry count, 0..DEPTH |
| rx_level | input | CNT_W (4) | Receive FIFO entry count, 0..DEPTH |
| shifter_busy | input | 1 | Serializer still shifting a frame |
| eot_mode | input | 1 | End-of-transmission meaning for the transmit flag |
| rx_timeout_evt | input | 1 | One-cycle receive time-out event |
| rx_overrun_evt | input | 1 | One-cycle receive overrun event |
| bus_sel | input | 1 | Register bus access in this cycle |
| bus_wr | input | 1 | Access is a write |
| bus_addr | input | ADDR_W (4) | Word address of the access |
| bus_wdata | input | 2 | Write data bits that can clear flags (bit 1 time-out, bit 0 overrun) |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| raw_flags | output | 4 | Unmasked flags {tx, rx, time-out, overrun} |

## Verification
A vector table drives combinations of `eot_mode`, `shifter_busy` and the two fill counts. The counts sit exactly on each side of the half threshold. Some rows set the serializer busy in watermark mode, which should change nothing, and others place a few entries in the FIFO in end-of-transmission mode, where the watermark flag would be set but the mode flag must not be. This separates an off-by-one comparison from a swapped mode decode. Directed sequences follow:

- a latency probe taken before and after the clock edge;
- sticky flags held across idle cycles;
- clear writes with the other bit's value and with zero data;
- writes aimed at the status address;
- a set pulse that coincides with its own clear.

Together these tell a working clear from a flag that is cleared by a wrong bit or address, or that loses to its own clear.

// File: rtl/ssp_irq_pkg.sv
// Package: ssp_irq_pkg
// Shared constants and the flag layout for the serial port raw interrupt
// status block. The bit positions are visible to software and are decoded
// by the downstream mask logic, so they must not be reordered.
package ssp_irq_pkg;

    localparam int DATA_W  = 32;  // register bus data width
    localparam int FLAG_W  = 4;   // number of raw flags
    localparam int EVT_W   = 2;   // number of sticky event flags

    localparam int BIT_OVR = 0;   // receive overrun
    localparam int BIT_TMO = 1;   // receive time-out
    localparam int BIT_RX  = 2;   // receive watermark
    localparam int BIT_TX  = 3;   // transmit watermark / end of transmission

    // Flag word, MSB first so the packed bit indices match BIT_* above.
    typedef struct packed {
        logic tx;
        logic rx;
        logic tmo;
        logic ovr;
    } raw_flags_t;

endpackage

// File: rtl/ssp_level_flags.sv
// Module: ssp_level_flags
// Registers the two level-based flags from the FIFO fill counts.
// Transmit: watermark (count <= DEPTH/2) or, in end-of-transmission mode,
// FIFO empty with an idle serializer. Receive: count >= DEPTH/2.
// Assumes the counts are in 0..DEPTH and synchronous to clk.
module ssp_level_flags #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH) + 1,
    localparam int HALF  = DEPTH / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tx_level,
    input  logic [CNT_W-1:0] rx_level,
    input  logic             shifter_busy,
    input  logic             eot_mode,
    output logic             tx_flag,
    output logic             rx_flag
);

    localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(HALF);

    logic tx_next;
    logic rx_next;
    logic armed;

    // Next transmit flag: the mode bit selects the end-of-transmission
    // condition or the half-empty watermark.
    always_comb begin
        if (eot_mode) begin
            tx_next = (tx_level == '0) && !shifter_busy;
        end else begin
            tx_next = (tx_level <= HALF_CNT);
        end
    end

    // Next receive flag: set at or above half capacity.
    always_comb begin
        rx_next = (rx_level >= HALF_CNT);
    end

    // Flag registers; reset reflects an empty transmit FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_flag <= 1'b1;
            rx_flag <= 1'b0;
        end else begin
            tx_flag <= tx_next;
            rx_flag <= rx_next;
        end
    end

    // Marks that at least one flag update has taken place since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R4: in end-of-transmission mode, data in the FIFO keeps the flag low.
    assert_eot_data_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(eot_mode) && ($past(tx_level) != '0) |-> !tx_flag);

    // R4: in end-of-transmission mode, a busy serializer keeps the flag low.
    assert_eot_busy_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(eot_mode) && $past(shifter_busy) |-> !tx_flag);

    // R3: in watermark mode, more than half full means no transmit flag.
    assert_tx_above_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !$past(eot_mode) && ($past(tx_level) > HALF_CNT) |-> !tx_flag);

    // R5: below half capacity the receive flag must be clear.
    assert_rx_below_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
        armed && ($past(rx_level) < HALF_CNT) |-> !rx_flag);

    // R9: with stable inputs the level flags hold their value.
    assert_level_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $stable(tx_level) && $stable(rx_level) && $stable(eot_mode)
        && $stable(shifter_busy) |=> $stable(tx_flag) && $stable(rx_flag));

endmodule

// File: rtl/ssp_event_flag.sv
// Module: ssp_event_flag
// One sticky event flag: a set pulse latches it and a clear request drops it.
// If both arrive in the same cycle the set wins. Assumes set and clear are
// synchronous single-cycle strobes.
module ssp_event_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_req,
    output logic flag
);

    // Sticky flag register with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;
        else if (clr_req) flag <= 1'b0;
    end

    // R8: a coincident set and clear leaves the flag set.
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt && clr_req |=> flag);

    // R6 / R7: an event latches the flag.
    assert_event_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);

    // R6 / R7: without a clear request a set flag stays set.
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !clr_req |=> flag);

    // R8: the flag never rises without a set event.
    assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !flag && !set_evt |=> !flag);

endmodule

// File: rtl/ssp_irq_bus_port.sv
// Module: ssp_irq_bus_port
// Register bus decode. It turns clear-register writes into per-flag clear
// requests and returns the zero-extended status word on reads of the status
// address. Assumes single-cycle write strobes. Reads are combinational on
// the address.
module ssp_irq_bus_port
    import ssp_irq_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int STATUS_IDX = 0,
    parameter int CLEAR_IDX  = 1
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [EVT_W-1:0]  bus_wdata,
    input  raw_flags_t        flags,
    output logic [EVT_W-1:0]  clr_req,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_IDX);
    localparam logic [ADDR_W-1:0] CLEAR_A  = ADDR_W'(CLEAR_IDX);

    logic clr_hit;

    // Write decode: only the clear register produces clear requests.
    always_comb begin
        clr_hit = bus_sel && bus_wr && (bus_addr == CLEAR_A);
        clr_req = clr_hit ? bus_wdata : '0;
    end

    // Read mux: status word zero-extended, every other address reads zero.
    always_comb begin
        if (bus_addr == STATUS_A) begin
            bus_rdata = {{(DATA_W - FLAG_W){1'b0}}, flags};
        end else begin
            bus_rdata = '0;
        end
    end

    // R1: the upper bits of any read are zero.
    always_comb begin
        assert_upper_zero_R1: assert (bus_rdata[DATA_W-1:FLAG_W] == '0);
    end

endmodule

// File: rtl/ssp_raw_irq_status.sv
// Module: ssp_raw_irq_status
// Top of the serial port raw interrupt status block. It combines the
// registered level flags, two sticky event flags (time-out, overrun) and the
// register bus decode. Assumes every input is synchronous to clk and the
// event inputs are single-cycle pulses.
module ssp_raw_irq_status
    import ssp_irq_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int ADDR_W     = 4,
    parameter int STATUS_IDX = 0,
    parameter int CLEAR_IDX  = 1,
    localparam int CNT_W     = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  tx_level,
    input  logic [CNT_W-1:0]  rx_level,
    input  logic              shifter_busy,
    input  logic              eot_mode,
    input  logic              rx_timeout_evt,
    input  logic              rx_overrun_evt,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [3:0]        raw_flags
);

    raw_flags_t             flags;
    logic                   tx_flag;
    logic                   rx_flag;
    logic [EVT_W-1:0]       evt_set;
    logic [EVT_W-1:0]       evt_clr;
    logic [EVT_W-1:0]       evt_flag;

    localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_IDX);

    // Event inputs ordered by their flag bit position.
    always_comb begin
        evt_set[BIT_OVR] = rx_overrun_evt;
        evt_set[BIT_TMO] = rx_timeout_evt;
    end

    ssp_level_flags #(
        .DEPTH (DEPTH)
    ) u_level (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_level     (tx_level),
        .rx_level     (rx_level),
        .shifter_busy (shifter_busy),
        .eot_mode     (eot_mode),
        .tx_flag      (tx_flag),
        .rx_flag      (rx_flag)
    );

    for (genvar gi = 0; gi < EVT_W; gi++) begin : g_evt
        ssp_event_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_evt (evt_set[gi]),
            .clr_req (evt_clr[gi]),
            .flag    (evt_flag[gi])
        );
    end

    // Assemble the flag word from the level and event flags.
    always_comb begin
        flags.tx  = tx_flag;
        flags.rx  = rx_flag;
        flags.tmo = evt_flag[BIT_TMO];
        flags.ovr = evt_flag[BIT_OVR];
        raw_flags = flags;
    end

    ssp_irq_bus_port #(
        .ADDR_W     (ADDR_W),
        .STATUS_IDX (STATUS_IDX),
        .CLEAR_IDX  (CLEAR_IDX)
    ) u_bus (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .flags     (flags),
        .clr_req   (evt_clr),
        .bus_rdata (bus_rdata)
    );

    // R1: a write to the status address with no events leaves the event flags alone.
    assert_status_ro_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && bus_wr && (bus_addr == STATUS_A) && !rx_timeout_evt
        && !rx_overrun_evt |=> raw_flags[1:0] == $past(raw_flags[1:0]));

    // R1: a read of the status address mirrors the raw flags.
    always_comb begin
        if (bus_addr == STATUS_A) begin
            assert_read_mirror_R1: assert (bus_rdata[3:0] == raw_flags);
        end
    end

endmodule

// File: tb/ssp_raw_irq_status_tb.sv
// Bench for ssp_raw_irq_status: a vector table over the level flags, then
// directed tests for reset, latency and the sticky event flags.
module ssp_raw_irq_status_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 9;

    // Row: {eot, busy, tx_level[3:0], rx_level[3:0], exp_tx, exp_rx}
    localparam logic [11:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 4'd0, 4'd0, 1'b1, 1'b0},  // R3 empty, R5 empty
        {1'b0, 1'b0, 4'd4, 4'd3, 1'b1, 1'b0},  // R3 at half, R5 just below
        {1'b0, 1'b0, 4'd5, 4'd4, 1'b0, 1'b1},  // R3 just above, R5 at half
        {1'b0, 1'b0, 4'd8, 4'd8, 1'b0, 1'b1},  // full
        {1'b0, 1'b1, 4'd3, 4'd0, 1'b1, 1'b0},  // R3 busy ignored
        {1'b1, 1'b0, 4'd0, 4'd3, 1'b1, 1'b0},  // R4 empty and idle
        {1'b1, 1'b1, 4'd0, 4'd7, 1'b0, 1'b1},  // R4 empty but busy
        {1'b1, 1'b0, 4'd1, 4'd0, 1'b0, 1'b0},  // R4 one entry
        {1'b1, 1'b1, 4'd4, 4'd4, 1'b0, 1'b1}   // R4 watermark would be set
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  tx_level = '0;
    logic [3:0]  rx_level = '0;
    logic        shifter_busy = 1'b0;
    logic        eot_mode = 1'b0;
    logic        rx_timeout_evt = 1'b0;
    logic        rx_overrun_evt = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [1:0]  bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  raw_flags;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    ssp_raw_irq_status u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .tx_level       (tx_level),
        .rx_level       (rx_level),
        .shifter_busy   (shifter_busy),
        .eot_mode       (eot_mode),
        .rx_timeout_evt (rx_timeout_evt),
        .rx_overrun_evt (rx_overrun_evt),
        .bus_sel        (bus_sel),
        .bus_wr         (bus_wr),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .raw_flags      (raw_flags)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Read the status word; rdata is combinational on the address.
    task automatic read_status(input string req, input logic [31:0] exp);
        bus_addr = 4'd0;
        #1;
        check(req, bus_rdata, exp);
    endtask

    // One-cycle bus write starting at a falling edge.
    task automatic bus_write(input logic [3:0] addr, input logic [1:0] data);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = addr; bus_wdata = data;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 4'd0; bus_wdata = '0;
    endtask

    // One-cycle event pulse on the selected input (1 time-out, 0 overrun).
    task automatic pulse(input bit tmo);
        @(negedge clk);
        if (tmo) rx_timeout_evt = 1'b1; else rx_overrun_evt = 1'b1;
        @(negedge clk);
        rx_timeout_evt = 1'b0; rx_overrun_evt = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset value, checked both during and after reset.
        read_status("R2 reset word", 32'h8);
        rst_n = 1'b1;
        @(negedge clk);
        read_status("R2 word after release", 32'h8);
        check("R2 raw_flags", {28'd0, raw_flags}, 32'h8);
        bus_addr = 4'd1;
        #1;
        check("R1 clear register reads zero", bus_rdata, 32'h0);
        bus_addr = 4'd7;
        #1;
        check("R1 unused address reads zero", bus_rdata, 32'h0);

        // Vector table over the level flags (R3, R4, R5).
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            eot_mode     = VEC[i][11];
            shifter_busy = VEC[i][10];
            tx_level     = VEC[i][9:6];
            rx_level     = VEC[i][5:2];
            @(negedge clk);
            read_status($sformatf("R3/R4/R5 vector %0d", i),
                        {28'd0, VEC[i][1], VEC[i][0], 2'b00});
        end

        // R9: the change is not visible before the clock edge and is visible after it.
        @(negedge clk);
        eot_mode = 1'b0; shifter_busy = 1'b0; tx_level = 4'd0; rx_level = 4'd0;
        @(negedge clk);
        tx_level = 4'd8; rx_level = 4'd6;
        read_status("R9 before edge", 32'h8);
        @(negedge clk);
        read_status("R9 after edge", 32'h4);
        tx_level = 4'd0; eot_mode = 1'b1; shifter_busy = 1'b1; rx_level = 4'd0;
        read_status("R9 mode change before edge", 32'h4);
        @(negedge clk);
        read_status("R9 mode change after edge", 32'h0);
        shifter_busy = 1'b0;
        @(negedge clk);
        read_status("R4 serializer done", 32'h8);
        eot_mode = 1'b0;

        // R6: the time-out flag is sticky and cleared only by bit 1.
        pulse(1'b1);
        read_status("R6 time-out latched", 32'ha);
        repeat (4) @(negedge clk);
        read_status("R6 time-out held", 32'ha);
        bus_write(4'd1, 2'b00);
        read_status("R8 zero write keeps time-out", 32'ha);
        bus_write(4'd1, 2'b01);
        read_status("R8 overrun-bit write keeps time-out", 32'ha);
        bus_write(4'd0, 2'b11);
        read_status("R1 status write ignored", 32'ha);
        bus_write(4'd1, 2'b10);
        read_status("R6 time-out cleared", 32'h8);

        // R7: the overrun flag is sticky and cleared only by bit 0.
        pulse(1'b0);
        read_status("R7 overrun latched", 32'h9);
        bus_write(4'd1, 2'b10);
        read_status("R7 time-out-bit write keeps overrun", 32'h9);
        bus_write(4'd2, 2'b11);
        read_status("R1 other address write ignored", 32'h9);
        bus_write(4'd1, 2'b01);
        read_status("R7 overrun cleared", 32'h8);

        // R8: a set and a clear in the same cycle leave the flag set.
        @(negedge clk);
        rx_timeout_evt = 1'b1; rx_overrun_evt = 1'b1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'd1; bus_wdata = 2'b11;
        @(negedge clk);
        rx_timeout_evt = 1'b0; rx_overrun_evt = 1'b0;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        read_status("R8 set wins over clear", 32'hb);
        bus_write(4'd1, 2'b11);
        read_status("R8 both cleared afterwards", 32'h8);

        // R2: a mid-run reset restores 0x8.
        pulse(1'b1);
        tx_level = 4'd7; rx_level = 4'd8;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        read_status("R2 mid-run reset", 32'h8);
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule